// File: doc/BRIEF.md
# Two-Argument Arctangent Special-Operand Resolver

This block sits in front of a single-precision atan2(y, x) datapath. Each cycle it may accept one operand pair, both binary32 words, with a valid strobe. It classifies both operands and decides whether the answer is fixed by the operand classes alone. Those classes are NaN, infinity and zero. If the answer is fixed, the block returns the exact binary32 result. The result is either a quieted NaN or a multiple of pi (0, pi/4, pi/2, 3pi/4, pi) that takes the sign bit of y. If the answer is not fixed, the block marks the pair for the arithmetic core and forwards the operands unchanged.

The cases are checked in a fixed priority order. NaN is checked first, x before y. Infinities come next, and zeros come last. Subnormal values count as ordinary nonzero finite numbers. Every accepted pair produces one response exactly one cycle later. There is no stall and no backpressure.

The output stage is a three-state machine. The states are `ST_IDLE` (no response this cycle), `ST_DONE` (a resolved result is presented) and `ST_PASS` (the pair is handed to the core). The next state is chosen on every clock edge by one of three named transitions:
- `T_NONE`: no input valid. Go to `ST_IDLE` from any state.
- `T_RESOLVE`: input valid and the pair is a special case. Go to `ST_DONE` from any state.
- `T_FORWARD`: input valid and the pair is ordinary. Go to `ST_PASS` from any state.

Top module: `atan2_special_resolve`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_done` and `out_pass` are 0, whatever is driven on the inputs.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. Back-to-back inputs give back-to-back responses. Whenever `out_valid` is 1, exactly one of `out_done` or `out_pass` is 1.
- R3: NaN means exponent field all ones and fraction nonzero. If x is NaN, the result is x with fraction bit 22 set. Otherwise, if y is NaN, the result is y with fraction bit 22 set. `out_done` is 1 in both cases.
- R4: A signaling NaN has exponent all ones, fraction nonzero and fraction bit 22 clear. `out_invalid` is 1 for a response exactly when either operand was a signaling NaN, and is 0 otherwise.
- R5: If x is +infinity and neither operand is NaN, the result is pi/4 (0x3F490FDB) when y is infinite and zero when y is finite. Bit 31 of the result is y's sign.
- R6: If x is -infinity and neither operand is NaN, the result is 3pi/4 (0x4016CBE4) when y is infinite and pi (0x40490FDB) when y is finite. Bit 31 of the result is y's sign.
- R7: If x is finite and y is infinite, the result is pi/2 (0x3FC90FDB) with y's sign.
- R8: If x is +0 or -0 and y is finite nonzero (subnormal included), the result is pi/2 with y's sign.
- R9: If y is +0 or -0 and x is finite, the result is signed zero when x's sign bit is 0. It is pi when x's sign bit is 1, subnormal or zero x included. The sign of the result is y's sign.
- R10: For any other pair, `out_pass`=1, `out_done`=0 and `out_result`=0.
- R11: `out_y`/`out_x` always carry the operands of the pair being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_y | input | 32 | Operand y, binary32 |
| in_x | input | 32 | Operand x, binary32 |
| out_valid | output | 1 | Response present |
| out_done | output | 1 | Result fully resolved here |
| out_pass | output | 1 | Pair must go to the arithmetic core |
| out_result | output | 32 | Resolved binary32 result, 0 on pass |
| out_invalid | output | 1 | A signaling NaN operand was seen |
| out_y | output | 32 | Forwarded operand y |
| out_x | output | 32 | Forwarded operand x |

## Verification
NaN quieting and the invalid flag can both act on one response, and so can the x-before-y NaN priority. The bench provokes this with a signaling NaN in x and a quiet NaN in y. It checks that the returned word is x with only bit 22 added and that `out_invalid` is raised anyway. The reverse pairing, a quiet NaN in x and a signaling NaN in y, must return x unchanged while still flagging invalid, because the flag comes from y. A second collision arises when the y-zero and x-zero rules both apply. Both-zero pairs are checked so that the sign of x alone selects between signed zero and pi.

// File: rtl/atan2_sr_pkg.sv
package atan2_sr_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = WORD_W - 1;

    // Magnitudes of the returned multiples of pi (sign bit supplied by y)
    localparam logic [MAG_W-1:0] MAG_ZERO   = '0;
    localparam logic [MAG_W-1:0] MAG_PI_Q   = MAG_W'(32'h3F490FDB);
    localparam logic [MAG_W-1:0] MAG_PI_H   = MAG_W'(32'h3FC90FDB);
    localparam logic [MAG_W-1:0] MAG_PI_3Q  = MAG_W'(32'h4016CBE4);
    localparam logic [MAG_W-1:0] MAG_PI     = MAG_W'(32'h40490FDB);

    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W - 1);

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } opnd_class_t;

    typedef enum logic [3:0] {
        K_NAN_X,
        K_NAN_Y,
        K_PINF_YINF,
        K_PINF_YFIN,
        K_NINF_YINF,
        K_NINF_YFIN,
        K_YINF,
        K_XZERO,
        K_YZERO_XPOS,
        K_YZERO_XNEG,
        K_CORE
    } case_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_PASS
    } out_state_t;

endpackage

// File: rtl/fp_operand_classify.sv
module fp_operand_classify
    import atan2_sr_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int F_W = FRAC_W
) (
    input  logic [E_W+F_W:0] word,
    output opnd_class_t      cls
);
    logic [E_W-1:0] exp_f;
    logic [F_W-1:0] frac_f;
    logic           exp_max;
    logic           exp_min;
    logic           frac_nz;

    always_comb begin
        exp_f   = word[E_W+F_W-1:F_W];
        frac_f  = word[F_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;

        cls.sign    = word[E_W+F_W];
        cls.is_nan  = exp_max & frac_nz;
        cls.is_snan = exp_max & frac_nz & ~frac_f[F_W-1];
        cls.is_inf  = exp_max & ~frac_nz;
        cls.is_zero = exp_min & ~frac_nz;
    end
endmodule

// File: rtl/atan2_case_select.sv
module atan2_case_select
    import atan2_sr_pkg::*;
(
    input  logic [WORD_W-1:0] y_word,
    input  logic [WORD_W-1:0] x_word,
    input  opnd_class_t       y_cls,
    input  opnd_class_t       x_cls,
    output logic              special,
    output logic              invalid,
    output logic [WORD_W-1:0] result
);
    case_kind_t        kind;
    logic [MAG_W-1:0]  mag;

    // Priority chain: NaN (x first), infinities, zeros, then core
    always_comb begin
        if (x_cls.is_nan)
            kind = K_NAN_X;
        else if (y_cls.is_nan)
            kind = K_NAN_Y;
        else if (x_cls.is_inf && !x_cls.sign)
            kind = y_cls.is_inf ? K_PINF_YINF : K_PINF_YFIN;
        else if (x_cls.is_inf)
            kind = y_cls.is_inf ? K_NINF_YINF : K_NINF_YFIN;
        else if (y_cls.is_inf)
            kind = K_YINF;
        else if (x_cls.is_zero && !y_cls.is_zero)
            kind = K_XZERO;
        else if (y_cls.is_zero)
            kind = x_cls.sign ? K_YZERO_XNEG : K_YZERO_XPOS;
        else
            kind = K_CORE;
    end

    always_comb begin
        mag     = MAG_ZERO;
        result  = '0;
        special = 1'b1;
        unique case (kind)
            K_NAN_X:      result = x_word | QUIET_MASK;
            K_NAN_Y:      result = y_word | QUIET_MASK;
            K_PINF_YINF:  mag = MAG_PI_Q;
            K_PINF_YFIN:  mag = MAG_ZERO;
            K_NINF_YINF:  mag = MAG_PI_3Q;
            K_NINF_YFIN:  mag = MAG_PI;
            K_YINF:       mag = MAG_PI_H;
            K_XZERO:      mag = MAG_PI_H;
            K_YZERO_XPOS: mag = MAG_ZERO;
            K_YZERO_XNEG: mag = MAG_PI;
            K_CORE:       special = 1'b0;
            default:      special = 1'b0;
        endcase
        if (special && kind != K_NAN_X && kind != K_NAN_Y)
            result = {y_cls.sign, mag};
    end

    assign invalid = x_cls.is_snan | y_cls.is_snan;
endmodule

// File: rtl/atan2_special_resolve.sv
module atan2_special_resolve
    import atan2_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_y,
    input  logic [WORD_W-1:0] in_x,
    output logic              out_valid,
    output logic              out_done,
    output logic              out_pass,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid,
    output logic [WORD_W-1:0] out_y,
    output logic [WORD_W-1:0] out_x
);
    localparam int N_OPND = 2;

    logic [WORD_W-1:0] opnd_word [N_OPND];
    opnd_class_t       opnd_cls  [N_OPND];

    assign opnd_word[0] = in_y;
    assign opnd_word[1] = in_x;

    for (genvar k = 0; k < N_OPND; k++) begin : g_cls
        fp_operand_classify #(.E_W(EXP_W), .F_W(FRAC_W)) u_cls (
            .word (opnd_word[k]),
            .cls  (opnd_cls[k])
        );
    end

    logic              sel_special;
    logic              sel_invalid;
    logic [WORD_W-1:0] sel_result;

    atan2_case_select u_sel (
        .y_word  (in_y),
        .x_word  (in_x),
        .y_cls   (opnd_cls[0]),
        .x_cls   (opnd_cls[1]),
        .special (sel_special),
        .invalid (sel_invalid),
        .result  (sel_result)
    );

    out_state_t        state_q, state_d;
    logic [WORD_W-1:0] res_q, y_q, x_q;
    logic              inv_q;

    // Transitions T_NONE / T_RESOLVE / T_FORWARD
    always_comb begin
        if (!in_valid)
            state_d = ST_IDLE;
        else if (sel_special)
            state_d = ST_DONE;
        else
            state_d = ST_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            inv_q <= 1'b0;
            y_q   <= '0;
            x_q   <= '0;
        end else if (in_valid) begin
            res_q <= sel_special ? sel_result : '0;
            inv_q <= sel_invalid;
            y_q   <= in_y;
            x_q   <= in_x;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_done    = 1'b0;
        out_pass    = 1'b0;
        out_result  = '0;
        out_invalid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: begin
                out_valid   = 1'b1;
                out_done    = 1'b1;
                out_result  = res_q;
                out_invalid = inv_q;
            end
            ST_PASS: begin
                out_valid   = 1'b1;
                out_pass    = 1'b1;
                out_invalid = inv_q;
            end
            default: ;
        endcase
        out_y = y_q;
        out_x = x_q;
    end
endmodule

// File: rtl/atan2_sr_checker.sv
module atan2_sr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_y,
    input logic [31:0] in_x,
    input logic        out_valid,
    input logic        out_done,
    input logic        out_pass,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic [31:0] out_y,
    input logic [31:0] out_x
);
    logic x_nan, y_nan, x_snan, y_snan, x_fin, y_inf;
    logic started;

    always_comb begin
        x_nan  = (&in_x[30:23]) && (|in_x[22:0]);
        y_nan  = (&in_y[30:23]) && (|in_y[22:0]);
        x_snan = x_nan && !in_x[22];
        y_snan = y_nan && !in_y[22];
        x_fin  = !(&in_x[30:23]);
        y_inf  = (&in_y[30:23]) && !(|in_y[22:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n || !started)
        in_valid |=> out_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n || !started)
        !in_valid |=> !out_valid);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({out_done, out_pass}));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_done && !out_pass));

    p_nan_x_r3: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (in_valid && x_nan) |=> (out_done && out_result == ($past(in_x) | 32'h0040_0000)));

    p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n || !started)
        in_valid |=> (out_invalid == $past(x_snan || y_snan)));

    p_yinf_r7: assert property (@(posedge clk) disable iff (!rst_n || !started)
        (in_valid && x_fin && y_inf) |=> (out_result == {$past(in_y[31]), 31'h3FC9_0FDB}));

    p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_pass |-> (out_result == 32'h0));

    p_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n || !started)
        in_valid |=> (out_x == $past(in_x) && out_y == $past(in_y)));
endmodule

bind atan2_special_resolve atan2_sr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_y        (in_y),
    .in_x        (in_x),
    .out_valid   (out_valid),
    .out_done    (out_done),
    .out_pass    (out_pass),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_y       (out_y),
    .out_x       (out_x)
);

// File: tb/atan2_special_resolve_test.sv
`timescale 1ns/1ps
module atan2_special_resolve_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_y = '0;
    logic [31:0] in_x = '0;
    logic        out_valid, out_done, out_pass, out_invalid;
    logic [31:0] out_result, out_y, out_x;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
    localparam logic [31:0] PI_Q = 32'h3F49_0FDB, PI_H = 32'h3FC9_0FDB;
    localparam logic [31:0] PI_3Q = 32'h4016_CBE4, PI_F = 32'h4049_0FDB;

    always #2 clk = ~clk;

    atan2_special_resolve uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y), .in_x(in_x),
        .out_valid(out_valid), .out_done(out_done), .out_pass(out_pass),
        .out_result(out_result), .out_invalid(out_invalid),
        .out_y(out_y), .out_x(out_x)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] y, input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1; in_y = y; in_x = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_special(input string tag, input logic [31:0] y,
                                  input logic [31:0] x, input logic [31:0] exp,
                                  input bit exp_inv);
        issue(y, x);
        chk(out_valid && out_done && !out_pass, {tag, " done"},
            {29'b0, out_valid, out_done, out_pass}, 32'h6);
        chk(out_result == exp, {tag, " result"}, out_result, exp);
        chk(out_invalid == exp_inv, {tag, " invalid R4"}, {31'b0, out_invalid}, {31'b0, exp_inv});
    endtask

    task automatic t_reset();
        in_valid = 1'b1; in_y = PINF; in_x = PINF;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_done && !out_pass, "R1 during reset",
            {29'b0, out_valid, out_done, out_pass}, 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_done && !out_pass, "R1 after reset",
            {29'b0, out_valid, out_done, out_pass}, 32'h0);
    endtask

    task automatic t_nan();
        expect_special("R3 qnan x", 32'h3F80_0000, 32'h7FC0_0001, 32'h7FC0_0001, 1'b0);
        expect_special("R3 snan x over qnan y", 32'hFFC0_0000, 32'h7F80_0005, 32'h7FC0_0005, 1'b1);
        expect_special("R3 qnan x over snan y", 32'hFF80_0010, 32'hFFC0_1234, 32'hFFC0_1234, 1'b1);
        expect_special("R3 snan y", 32'hFF80_0010, 32'h3F80_0000, 32'hFFC0_0010, 1'b1);
        expect_special("R3 nan y with inf x", 32'h7FC0_0000, PINF, 32'h7FC0_0000, 1'b0);
    endtask

    task automatic t_pos_inf();
        expect_special("R5 +inf,-inf", NINF, PINF, PI_Q | 32'h8000_0000, 1'b0);
        expect_special("R5 +inf,+inf", PINF, PINF, PI_Q, 1'b0);
        expect_special("R5 +inf,+3", 32'h4040_0000, PINF, PZ, 1'b0);
        expect_special("R5 +inf,-3", 32'hC040_0000, PINF, NZ, 1'b0);
    endtask

    task automatic t_neg_inf();
        expect_special("R6 -inf,+inf", PINF, NINF, PI_3Q, 1'b0);
        expect_special("R6 -inf,-inf", NINF, NINF, PI_3Q | 32'h8000_0000, 1'b0);
        expect_special("R6 -inf,-1", 32'hBF80_0000, NINF, PI_F | 32'h8000_0000, 1'b0);
        expect_special("R6 -inf,-0", NZ, NINF, PI_F | 32'h8000_0000, 1'b0);
    endtask

    task automatic t_y_inf();
        expect_special("R7 x=5,-inf", NINF, 32'h40A0_0000, PI_H | 32'h8000_0000, 1'b0);
        expect_special("R7 x=+0,+inf", PINF, PZ, PI_H, 1'b0);
    endtask

    task automatic t_x_zero();
        expect_special("R8 -0,subnormal y", 32'h0000_0001, NZ, PI_H, 1'b0);
        expect_special("R8 +0,-2", 32'hC000_0000, PZ, PI_H | 32'h8000_0000, 1'b0);
    endtask

    task automatic t_y_zero();
        expect_special("R9 +0 x,-0 y", NZ, PZ, NZ, 1'b0);
        expect_special("R9 -0 x,+0 y", PZ, NZ, PI_F, 1'b0);
        expect_special("R9 x=7,+0", PZ, 32'h40E0_0000, PZ, 1'b0);
        expect_special("R9 x=-7,-0", NZ, 32'hC0E0_0000, PI_F | 32'h8000_0000, 1'b0);
        expect_special("R9 neg subnormal x", PZ, 32'h8000_0001, PI_F, 1'b0);
    endtask

    task automatic t_pass();
        issue(32'h3F80_0000, 32'h3F80_0000);
        chk(out_valid && out_pass && !out_done, "R10 pass 1,1",
            {29'b0, out_valid, out_done, out_pass}, 32'h5);
        chk(out_result == 32'h0, "R10 result zero", out_result, 32'h0);
        chk(out_x == 32'h3F80_0000 && out_y == 32'h3F80_0000, "R11 forward", out_x, 32'h3F80_0000);
        issue(32'h8000_0002, 32'h0000_0003);
        chk(out_pass && !out_done, "R10 pass subnormals",
            {30'b0, out_done, out_pass}, 32'h1);
        chk(out_y == 32'h8000_0002, "R11 forward y", out_y, 32'h8000_0002);
        chk(out_x == 32'h0000_0003, "R11 forward x", out_x, 32'h0000_0003);
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1'b1; in_y = PINF; in_x = 32'h4000_0000;
        @(negedge clk);
        chk(out_valid && out_done && out_result == PI_H, "R2 stream first", out_result, PI_H);
        in_y = 32'h4000_0000; in_x = 32'h4000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_pass && out_x == 32'h4000_0000, "R2 stream second",
            {31'b0, out_pass}, 32'h1);
        @(negedge clk);
        chk(!out_valid && !out_done && !out_pass, "R2 idle after stream",
            {29'b0, out_valid, out_done, out_pass}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_nan();
        t_pos_inf();
        t_neg_inf();
        t_y_inf();
        t_x_zero();
        t_y_zero();
        t_pass();
        t_stream();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule